// File: doc/BRIEF.md
# Dual-Port Mailbox Doorbell Interrupt Controller

This block is a register file that lets a host on the far side of a PCI Express link and a local processor pass messages to each other. Each direction has eight 32-bit mailboxes. The side that sends owns the write access to its mailboxes. The side that receives can only read them.

Every write to a mailbox also acts as a doorbell. On the receiving side, the write sets a sticky status bit, one bit per mailbox. The receiver clears that bit by writing 1 to it. A per-bit enable register masks the status bits, and the result drives a single level interrupt toward the receiver.

Both sides reach the block through a plain register port. Each port has single-cycle write and read strobes, a byte address, write data and byte enables. Read data is registered and appears one clock after the read strobe.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset, every mailbox, status and enable register reads zero, and both `l_irq` and `h_irq` are low.
- R2: A host write to host-to-local mailbox n updates only the byte lanes whose `h_be` bit is 1. The host-to-local mailboxes sit at host offset 0x0800+4n and local offset 0x3B00+4n, and both ports read the same value there.
- R3: Any host write to host-to-local mailbox n sets bit 16+n of the local status register (offset 0x3060), whatever the byte enables are, including all zero.
- R4: A local write to the status register clears each bit in 23:16 whose write-data bit is 1 and leaves the bits written with 0 unchanged. Bits 15:0 and 31:24 always read zero.
- R5: The local enable register (offset 0x3070) keeps whatever is written to bits 23:16. All of its other bits read zero.
- R6: `l_irq` is high exactly while some local status bit 16+n and enable bit 16+n are both 1.
- R7: A local write to local-to-host mailbox n updates only the enabled byte lanes and sets bit n of the host status register (host offset 0x0040). The local-to-host mailboxes sit at local offset 0x3A00+4n and host offset 0x0900+4n. The host clears host status bit n by writing 1 to it, and bits 31:8 read zero.
- R8: The host enable register (host offset 0x0050) keeps bits 7:0. `h_irq` is high exactly while some host status bit and its enable bit are both 1.
- R9: If a doorbell set and a write-1-to-clear of the same status bit fall in the same cycle, the bit ends up set. This holds on both sides.
- R10: Local writes to host-to-local mailbox addresses and host writes to local-to-host mailbox addresses change no mailbox data and set no status bit.
- R11: A read strobe loads the addressed value into the port's read-data register at the next clock edge. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 16 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_be | input | 4 | Host byte enables |
| h_rdata | output | 32 | Host read data, registered |
| h_irq | output | 1 | Level interrupt toward the host |
| l_wr | input | 1 | Local write strobe |
| l_rd | input | 1 | Local read strobe |
| l_addr | input | 16 | Local byte address |
| l_wdata | input | 32 | Local write data |
| l_be | input | 4 | Local byte enables |
| l_rdata | output | 32 | Local read data, registered |
| l_irq | output | 1 | Level interrupt toward the local processor |

## Verification
The hardest case to reach is a doorbell set and a clear of the same status bit landing on one clock edge. The set and the clear come from different ports, so the normal one-access-at-a-time tasks never line them up. A dedicated task therefore drives the host mailbox write and the local write-1-to-clear on the same falling edge, and then drives the mirror case on the host side. A zero-byte-enable mailbox write and writes aimed at the read-only mailbox windows are also driven on purpose, so that the doorbell and the ignore rules can be told apart at the ports.

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
  parameter int NMB = 8,
  parameter int DW  = 32,
  parameter int AW  = 16,
  parameter int DB_LSB = 16,
  parameter logic [AW-1:0] L_L2H_BASE = 16'h3A00,
  parameter logic [AW-1:0] L_H2L_BASE = 16'h3B00,
  parameter logic [AW-1:0] L_STAT     = 16'h3060,
  parameter logic [AW-1:0] L_EN       = 16'h3070,
  parameter logic [AW-1:0] H_H2L_BASE = 16'h0800,
  parameter logic [AW-1:0] H_L2H_BASE = 16'h0900,
  parameter logic [AW-1:0] H_STAT     = 16'h0040,
  parameter logic [AW-1:0] H_EN       = 16'h0050
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_wr,
  input  logic          h_rd,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  input  logic [DW/8-1:0] h_be,
  output logic [DW-1:0] h_rdata,
  output logic          h_irq,
  input  logic          l_wr,
  input  logic          l_rd,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  input  logic [DW/8-1:0] l_be,
  output logic [DW-1:0] l_rdata,
  output logic          l_irq
);
  localparam int BW  = DW / 8;
  localparam int WB  = $clog2(BW);
  localparam int IW  = $clog2(NMB);
  localparam int WIN = IW + WB;

  logic [NMB-1:0][DW-1:0] h2l, l2h;
  logic [NMB-1:0] l_stat, l_en, h_stat, h_en;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_v,
                                          input logic [DW-1:0] new_v,
                                          input logic [BW-1:0] be);
    logic [DW-1:0] r;
    for (int b = 0; b < BW; b++)
      r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    return r;
  endfunction

  wire h_in_h2l = h_addr[AW-1:WIN] == H_H2L_BASE[AW-1:WIN];
  wire h_in_l2h = h_addr[AW-1:WIN] == H_L2H_BASE[AW-1:WIN];
  wire h_is_st  = h_addr[AW-1:WB]  == H_STAT[AW-1:WB];
  wire h_is_en  = h_addr[AW-1:WB]  == H_EN[AW-1:WB];
  wire l_in_l2h = l_addr[AW-1:WIN] == L_L2H_BASE[AW-1:WIN];
  wire l_in_h2l = l_addr[AW-1:WIN] == L_H2L_BASE[AW-1:WIN];
  wire l_is_st  = l_addr[AW-1:WB]  == L_STAT[AW-1:WB];
  wire l_is_en  = l_addr[AW-1:WB]  == L_EN[AW-1:WB];
  wire [IW-1:0] h_idx = h_addr[WIN-1:WB];
  wire [IW-1:0] l_idx = l_addr[WIN-1:WB];

  logic [NMB-1:0] l_set, l_clr, h_set, h_clr;

  genvar n;
  generate
    for (n = 0; n < NMB; n++) begin : g_mb
      assign l_set[n] = h_wr && h_in_h2l && h_idx == IW'(n);
      assign h_set[n] = l_wr && l_in_l2h && l_idx == IW'(n);
      assign l_clr[n] = l_wr && l_is_st && l_wdata[DB_LSB+n];
      assign h_clr[n] = h_wr && h_is_st && h_wdata[n];

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        h2l[n] <= '0;
        else if (l_set[n]) h2l[n] <= merge(h2l[n], h_wdata, h_be);

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        l2h[n] <= '0;
        else if (h_set[n]) l2h[n] <= merge(l2h[n], l_wdata, l_be);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      l_stat <= '0;
      h_stat <= '0;
      l_en   <= '0;
      h_en   <= '0;
    end else begin
      l_stat <= (l_stat & ~l_clr) | l_set;
      h_stat <= (h_stat & ~h_clr) | h_set;
      if (l_wr && l_is_en) l_en <= l_wdata[DB_LSB +: NMB];
      if (h_wr && h_is_en) h_en <= h_wdata[NMB-1:0];
    end

  logic [DW-1:0] l_rv, h_rv;
  always_comb begin
    l_rv = '0;
    if (l_in_l2h)     l_rv = l2h[l_idx];
    else if (l_in_h2l) l_rv = h2l[l_idx];
    else if (l_is_st)  l_rv = DW'(l_stat) << DB_LSB;
    else if (l_is_en)  l_rv = DW'(l_en) << DB_LSB;
  end

  always_comb begin
    h_rv = '0;
    if (h_in_h2l)     h_rv = h2l[h_idx];
    else if (h_in_l2h) h_rv = l2h[h_idx];
    else if (h_is_st)  h_rv = DW'(h_stat);
    else if (h_is_en)  h_rv = DW'(h_en);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      l_rdata <= '0;
      h_rdata <= '0;
    end else begin
      if (l_rd) l_rdata <= l_rv;
      if (h_rd) h_rdata <= h_rv;
    end

  assign l_irq = |(l_stat & l_en);
  assign h_irq = |(h_stat & h_en);
endmodule

module mbox_doorbell_chk #(
  parameter int NMB = 8,
  parameter int DW  = 32,
  parameter int AW  = 16,
  parameter int DB_LSB = 16,
  parameter logic [AW-1:0] L_L2H_BASE = 16'h3A00,
  parameter logic [AW-1:0] L_H2L_BASE = 16'h3B00,
  parameter logic [AW-1:0] L_STAT     = 16'h3060,
  parameter logic [AW-1:0] H_H2L_BASE = 16'h0800
) (
  input logic clk,
  input logic rst_n,
  input logic h_wr,
  input logic [AW-1:0] h_addr,
  input logic l_wr,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_wdata,
  input logic l_irq,
  input logic h_irq,
  input logic [NMB-1:0] l_stat,
  input logic [NMB-1:0] h_stat,
  input logic [NMB-1:0][DW-1:0] h2l
);
  localparam int WB  = $clog2(DW / 8);
  localparam int IW  = $clog2(NMB);
  localparam int WIN = IW + WB;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (l_stat == '0 && h_stat == '0 && !l_irq && !h_irq));

  // R6
  l_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_irq |-> (l_stat != '0));

  // R8
  h_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq |-> (h_stat != '0));

  // R10
  h2l_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && l_addr[AW-1:WIN] == L_H2L_BASE[AW-1:WIN] && !h_wr) |=> $stable(h2l));

  genvar n;
  generate
    for (n = 0; n < NMB; n++) begin : g_chk
      // R3
      doorbell_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr[AW-1:WIN] == H_H2L_BASE[AW-1:WIN] && h_addr[WIN-1:WB] == IW'(n))
        |=> l_stat[n]);

      // R7
      host_bell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wr && l_addr[AW-1:WIN] == L_L2H_BASE[AW-1:WIN] && l_addr[WIN-1:WB] == IW'(n))
        |=> h_stat[n]);

      // R4
      w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wr && l_addr[AW-1:WB] == L_STAT[AW-1:WB] && l_wdata[DB_LSB+n] &&
         !(h_wr && h_addr[AW-1:WIN] == H_H2L_BASE[AW-1:WIN] && h_addr[WIN-1:WB] == IW'(n)))
        |=> !l_stat[n]);
    end
  endgenerate
endmodule

bind mbox_doorbell mbox_doorbell_chk #(
  .NMB(NMB), .DW(DW), .AW(AW), .DB_LSB(DB_LSB),
  .L_L2H_BASE(L_L2H_BASE), .L_H2L_BASE(L_H2L_BASE),
  .L_STAT(L_STAT), .H_H2L_BASE(H_H2L_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr),
  .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata),
  .l_irq(l_irq), .h_irq(h_irq), .l_stat(l_stat), .h_stat(h_stat), .h2l(h2l)
);

// File: tb/tb_mbox_doorbell.sv
module tb_mbox_doorbell;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        h_wr = 0, h_rd = 0, l_wr = 0, l_rd = 0;
  logic [15:0] h_addr = 0, l_addr = 0;
  logic [31:0] h_wdata = 0, l_wdata = 0;
  logic [3:0]  h_be = 0, l_be = 0;
  logic [31:0] h_rdata, l_rdata;
  logic        h_irq, l_irq;

  int vectors = 0, errors = 0;

  mbox_doorbell dut (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata), .h_be(h_be),
    .h_rdata(h_rdata), .h_irq(h_irq),
    .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_wdata(l_wdata), .l_be(l_be),
    .l_rdata(l_rdata), .l_irq(l_irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic hw(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk); h_wr = 1; h_addr = a; h_wdata = d; h_be = be;
    @(negedge clk); h_wr = 0;
  endtask

  task automatic lw(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk); l_wr = 1; l_addr = a; l_wdata = d; l_be = be;
    @(negedge clk); l_wr = 0;
  endtask

  task automatic hr(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); h_rd = 1; h_addr = a;
    @(negedge clk); h_rd = 0; d = h_rdata;
  endtask

  task automatic lr(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); l_rd = 1; l_addr = a;
    @(negedge clk); l_rd = 0; d = l_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    lr(16'h3060, v); check("R1 lstat", v, 0);
    lr(16'h3070, v); check("R1 len", v, 0);
    lr(16'h3B1C, v); check("R1 h2l7", v, 0);
    hr(16'h0040, v); check("R1 hstat", v, 0);
    check("R1 irqs", {30'd0, l_irq, h_irq}, 0);
  endtask

  task automatic t_h2l;
    logic [31:0] v;
    hw(16'h080C, 32'hCAFEF00D, 4'hF);
    lr(16'h3B0C, v); check("R2 local view", v, 32'hCAFEF00D);
    hw(16'h080C, 32'h11223344, 4'b0101);
    lr(16'h3B0C, v); check("R2 byte lanes", v, 32'hCA22F044);
    hr(16'h080C, v); check("R2 host view", v, 32'hCA22F044);
    lr(16'h3060, v); check("R3 bit19", v, 32'h0008_0000);
    hw(16'h0814, 32'hFFFFFFFF, 4'h0);
    lr(16'h3B14, v); check("R2 be zero data", v, 0);
    lr(16'h3060, v); check("R3 be zero bell", v, 32'h0028_0000);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    lw(16'h3060, 32'h0, 4'hF);
    lr(16'h3060, v); check("R4 write zero", v, 32'h0028_0000);
    lw(16'h3060, 32'hFF00FFFF, 4'hF);
    lr(16'h3060, v); check("R4 reserved ones", v, 32'h0028_0000);
    lw(16'h3060, 32'h0008_0000, 4'hF);
    lr(16'h3060, v); check("R4 clear bit19", v, 32'h0020_0000);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    check("R6 no enable", {31'd0, l_irq}, 0);
    lw(16'h3070, 32'hFFFFFFFF, 4'hF);
    lr(16'h3070, v); check("R5 enable mask", v, 32'h00FF_0000);
    check("R6 bit21 irq", {31'd0, l_irq}, 1);
    lw(16'h3070, 32'h0008_0000, 4'hF);
    check("R6 masked", {31'd0, l_irq}, 0);
    hw(16'h080C, 32'h0, 4'h0);
    check("R6 bit19 irq", {31'd0, l_irq}, 1);
    lw(16'h3060, 32'h00FF_0000, 4'hF);
    check("R6 cleared", {31'd0, l_irq}, 0);
    lr(16'h3060, v); check("R4 all clear", v, 0);
  endtask

  task automatic t_l2h;
    logic [31:0] v;
    lw(16'h3A08, 32'h12345678, 4'hF);
    hr(16'h0908, v); check("R7 host view", v, 32'h12345678);
    lw(16'h3A08, 32'hAABBCCDD, 4'b1000);
    lr(16'h3A08, v); check("R7 byte lanes", v, 32'hAA345678);
    hr(16'h0040, v); check("R7 hstat", v, 32'h4);
    check("R8 no enable", {31'd0, h_irq}, 0);
    hw(16'h0050, 32'hFFFFFFFF, 4'hF);
    hr(16'h0050, v); check("R8 enable read", v, 32'hFF);
    check("R8 irq", {31'd0, h_irq}, 1);
    hw(16'h0040, 32'h4, 4'hF);
    hr(16'h0040, v); check("R7 host w1c", v, 0);
    check("R8 irq clear", {31'd0, h_irq}, 0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    hw(16'h0800, 32'h0, 4'hF);
    @(negedge clk);
    h_wr = 1; h_addr = 16'h0800; h_wdata = 32'h5; h_be = 4'hF;
    l_wr = 1; l_addr = 16'h3060; l_wdata = 32'h0001_0000; l_be = 4'hF;
    @(negedge clk); h_wr = 0; l_wr = 0;
    lr(16'h3060, v); check("R9 local set wins", v, 32'h0001_0000);
    @(negedge clk);
    l_wr = 1; l_addr = 16'h3A04; l_wdata = 32'h9; l_be = 4'hF;
    h_wr = 1; h_addr = 16'h0040; h_wdata = 32'h2; h_be = 4'hF;
    @(negedge clk); h_wr = 0; l_wr = 0;
    hr(16'h0040, v); check("R9 host set wins", v, 32'h2);
    lw(16'h3060, 32'h00FF_0000, 4'hF);
    hw(16'h0040, 32'hFF, 4'hF);
  endtask

  task automatic t_ro;
    logic [31:0] v;
    lw(16'h3B0C, 32'hFFFFFFFF, 4'hF);
    lr(16'h3B0C, v); check("R10 h2l kept", v, 32'hCA22F044);
    lr(16'h3060, v); check("R10 no local bell", v, 0);
    hr(16'h0040, v); check("R10 no host bell", v, 0);
    hw(16'h0908, 32'h0, 4'hF);
    hr(16'h0908, v); check("R10 l2h kept", v, 32'hAA345678);
    hr(16'h0040, v); check("R10 host stat", v, 0);
    lr(16'h3060, v); check("R10 local stat", v, 0);
  endtask

  task automatic t_read;
    logic [31:0] v;
    lr(16'h1234, v); check("R11 local unmapped", v, 0);
    hr(16'h7FF0, v); check("R11 host unmapped", v, 0);
    @(negedge clk); l_rd = 1; l_addr = 16'h3A08;
    @(posedge clk); #1;
    check("R11 one cycle", l_rdata, 32'hAA345678);
    @(negedge clk); l_rd = 0; l_addr = 16'h3070;
    @(negedge clk);
    check("R11 held", l_rdata, 32'hAA345678);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_h2l;
    t_w1c;
    t_enable;
    t_l2h;
    t_collide;
    t_ro;
    t_read;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule